// File: doc/BRIEF.md
# Multi-Sensor SPI Read Sequencer

This block reads a short list of SPI sensors one after another after a single trigger, with no processor action between sensors. A table at its inputs gives, for each entry, the chip-select line to use, how the 24-bit reading is cut into SPI sub-frames of at most 16 bits, and whether the sensor delivers 20 or 24 significant bits. For every entry the sequencer issues the sub-frame commands to an SPI master over a valid/ready handshake. It keeps the chip select held until the final sub-frame and collects each returned sub-frame. It then joins them into one right-aligned word and writes that word to the result slot with the same index as the entry.

Only when every active entry has been stored does the block raise its interrupt. The interrupt is a level that stays high until a clear pulse, so a sleeping processor sees one event per run rather than one per word or per sensor. While a run is in progress a busy output is high, and further trigger pulses are dropped.

The controller is one state machine. The states are IDLE, LOAD, ISSUE, WAIT_RSP, STORE and DONE, and the transitions between them are:
- IDLE to LOAD on a trigger with a non-zero count.
- IDLE to DONE on a trigger with a zero count.
- LOAD to ISSUE, which clears the accumulator and the sub-frame index.
- ISSUE to WAIT_RSP when the master accepts the command.
- WAIT_RSP to ISSUE on a response that is not for the entry's last sub-frame.
- WAIT_RSP to STORE on the response to the last sub-frame.
- STORE to LOAD when more entries remain.
- STORE to DONE after the final entry.
- DONE to IDLE, which sets the interrupt.

Top module: `spi_sensor_seq`

## Requirements
- R1: A trigger in IDLE reads table entries 0 up to count-1 in ascending order and writes each result once, to the slot equal to its entry index. A count above 4 is treated as 4.
- R2: The interrupt rises exactly once per run, on the same clock edge where busy falls and after the last result write. It stays high until `clr_irq` is pulsed, and it is low on the cycle after that pulse.
- R3: Busy is high from the cycle after an accepted trigger until the interrupt rises.
- R4: A trigger pulse while busy is high has no effect. The run still yields exactly count writes and one interrupt, and no second run follows.
- R5: The 2-bit split code selects the sub-frame bit counts sent on `cmd_len`: 0 gives 16 then 8, 1 gives 12 then 12, 2 gives 8, 8, 8, and 3 gives 8 then 16.
- R6: Every sub-frame of an entry carries that entry's chip-select index on `cmd_cs`. `cmd_last`, which tells the master to release the select afterwards, is high only on the final sub-frame, once all 24 bits of the entry have been requested.
- R7: Each response supplies its bits right-aligned in `rsp_data`. The sub-frames are joined MSB first, so the first sub-frame holds the most significant bits of the 24-bit result.
- R8: An entry whose narrow flag is 1 (a 20-bit sensor) stores the 24-bit reading shifted right by 4, with the upper 4 bits zero.
- R9: A trigger with count 0 issues no command and makes no write. Busy is high for one cycle, and then the interrupt rises.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_len`, `cmd_cs` and `cmd_last` hold their values into the next cycle.
- R11: During and after reset, busy, irq, `cmd_valid` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Trigger pulse for one run |
| clr_irq | input | 1 | Clears the interrupt level |
| tbl_count | input | 3 | Number of active table entries |
| tbl_cs | input | 8 | Chip-select index per entry, 2 bits each, entry 0 in the low bits |
| tbl_split | input | 8 | Split code per entry, 2 bits each, entry 0 in the low bits |
| tbl_narrow | input | 4 | Per-entry 20-bit flag, bit i for entry i |
| cmd_valid | output | 1 | Sub-frame command valid |
| cmd_ready | input | 1 | Master accepts the command |
| cmd_cs | output | 2 | Chip-select index for the sub-frame |
| cmd_len | output | 5 | Sub-frame bit count |
| cmd_last | output | 1 | Release the chip select after this sub-frame |
| rsp_valid | input | 1 | Sub-frame response valid |
| rsp_data | input | 16 | Received bits, right-aligned |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 2 | Result slot index |
| wr_data | output | 24 | Result word |
| busy | output | 1 | Run in progress |
| irq | output | 1 | Run-complete interrupt level |

## Verification
The hardest case to reach from the ports is a second trigger that lands in the middle of a multi-entry run, while the handshake with the master is stalled, because the ignored pulse must leave no trace in the write count or the interrupt. The bench models the SPI master with a command latency and a response latency that change from sub-frame to sub-frame. It fires an extra trigger part-way through selected runs of two or more entries. A sweep over counts 0 to 5 combines rotated chip selects, every split code in every position and varied narrow flags, so each sensor's bit pointer and chip-select hold are checked against the sensor model at every sub-frame.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_ISSUE,
        S_WAIT_RSP,
        S_STORE,
        S_DONE
    } seq_state_t;

    localparam logic [1:0] SPLIT_WIDE_TAIL = 2'd0;
    localparam logic [1:0] SPLIT_HALVES    = 2'd1;
    localparam logic [1:0] SPLIT_THIRDS    = 2'd2;
    localparam logic [1:0] SPLIT_HEAD_WIDE = 2'd3;

endpackage

// File: rtl/sseq_split_dec.sv
module sseq_split_dec
    import sseq_pkg::*;
#(
    parameter int RES_W = 24,
    parameter int SUB_W = 16,
    parameter int LEN_W = 5
) (
    input  logic [1:0]       code,
    input  logic [1:0]       sub,
    output logic [LEN_W-1:0] len,
    output logic             last
);
    localparam int TAIL_LEN  = RES_W - SUB_W;
    localparam int HALF_LEN  = RES_W / 2;
    localparam int THIRD_LEN = RES_W / 3;

    always_comb begin
        len  = '0;
        last = 1'b0;
        unique case (code)
            SPLIT_WIDE_TAIL: begin
                len  = (sub == 2'd0) ? LEN_W'(SUB_W) : LEN_W'(TAIL_LEN);
                last = (sub != 2'd0);
            end
            SPLIT_HALVES: begin
                len  = LEN_W'(HALF_LEN);
                last = (sub != 2'd0);
            end
            SPLIT_THIRDS: begin
                len  = LEN_W'(THIRD_LEN);
                last = (sub == 2'd2);
            end
            SPLIT_HEAD_WIDE: begin
                len  = (sub == 2'd0) ? LEN_W'(TAIL_LEN) : LEN_W'(SUB_W);
                last = (sub != 2'd0);
            end
        endcase
    end
endmodule

// File: rtl/sseq_entry_sel.sv
module sseq_entry_sel #(
    parameter int N_SENS = 4,
    parameter int CS_W   = 2,
    parameter int IDX_W  = 2
) (
    input  logic [N_SENS*CS_W-1:0] tbl_cs,
    input  logic [N_SENS*2-1:0]    tbl_split,
    input  logic [N_SENS-1:0]      tbl_narrow,
    input  logic [IDX_W-1:0]       idx,
    output logic [CS_W-1:0]        sel_cs,
    output logic [1:0]             sel_split,
    output logic                   sel_narrow
);
    logic [CS_W-1:0] cs_arr    [N_SENS];
    logic [1:0]      split_arr [N_SENS];

    for (genvar g = 0; g < N_SENS; g++) begin : g_unpack
        assign cs_arr[g]    = tbl_cs[g*CS_W +: CS_W];
        assign split_arr[g] = tbl_split[g*2 +: 2];
    end

    assign sel_cs     = cs_arr[idx];
    assign sel_split  = split_arr[idx];
    assign sel_narrow = tbl_narrow[idx];
endmodule

// File: rtl/sseq_accum.sv
module sseq_accum #(
    parameter int RES_W = 24,
    parameter int SUB_W = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [LEN_W-1:0] len,
    input  logic [SUB_W-1:0] din,
    output logic [RES_W-1:0] acc
);
    logic [RES_W-1:0] mask;
    logic [RES_W-1:0] din_ext;

    always_comb begin
        mask    = (RES_W'(1) << len) - RES_W'(1);
        din_ext = RES_W'(din) & mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (take) begin
            acc <= (acc << len) | din_ext;
        end
    end

    // R7
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
endmodule

// File: rtl/spi_sensor_seq.sv
module spi_sensor_seq
    import sseq_pkg::*;
#(
    parameter int N_SENS       = 4,
    parameter int CS_W         = 2,
    parameter int RES_W        = 24,
    parameter int SUB_W        = 16,
    parameter int NARROW_SHIFT = 4,
    localparam int LEN_W       = $clog2(SUB_W + 1),
    localparam int IDX_W       = $clog2(N_SENS),
    localparam int CNT_W       = $clog2(N_SENS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   clr_irq,
    input  logic [CNT_W-1:0]       tbl_count,
    input  logic [N_SENS*CS_W-1:0] tbl_cs,
    input  logic [N_SENS*2-1:0]    tbl_split,
    input  logic [N_SENS-1:0]      tbl_narrow,
    output logic                   cmd_valid,
    input  logic                   cmd_ready,
    output logic [CS_W-1:0]        cmd_cs,
    output logic [LEN_W-1:0]       cmd_len,
    output logic                   cmd_last,
    input  logic                   rsp_valid,
    input  logic [SUB_W-1:0]       rsp_data,
    output logic                   wr_en,
    output logic [IDX_W-1:0]       wr_addr,
    output logic [RES_W-1:0]       wr_data,
    output logic                   busy,
    output logic                   irq
);
    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [1:0]       sub_q, sub_d;
    logic             irq_q;

    logic [CNT_W-1:0] eff_cnt;
    logic             final_entry;
    logic [CS_W-1:0]  ent_cs;
    logic [1:0]       ent_split;
    logic             ent_narrow;
    logic [LEN_W-1:0] sub_len;
    logic             sub_last;
    logic [RES_W-1:0] acc;
    logic             acc_clr;
    logic             acc_take;

    assign eff_cnt     = (tbl_count > CNT_W'(N_SENS)) ? CNT_W'(N_SENS) : tbl_count;
    assign final_entry = (CNT_W'(idx_q) == eff_cnt - CNT_W'(1));

    sseq_entry_sel #(
        .N_SENS (N_SENS),
        .CS_W   (CS_W),
        .IDX_W  (IDX_W)
    ) u_sel (
        .tbl_cs     (tbl_cs),
        .tbl_split  (tbl_split),
        .tbl_narrow (tbl_narrow),
        .idx        (idx_q),
        .sel_cs     (ent_cs),
        .sel_split  (ent_split),
        .sel_narrow (ent_narrow)
    );

    sseq_split_dec #(
        .RES_W (RES_W),
        .SUB_W (SUB_W),
        .LEN_W (LEN_W)
    ) u_dec (
        .code (ent_split),
        .sub  (sub_q),
        .len  (sub_len),
        .last (sub_last)
    );

    assign acc_clr  = (state_q == S_LOAD);
    assign acc_take = (state_q == S_WAIT_RSP) && rsp_valid;

    sseq_accum #(
        .RES_W (RES_W),
        .SUB_W (SUB_W),
        .LEN_W (LEN_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .take  (acc_take),
        .len   (sub_len),
        .din   (rsp_data),
        .acc   (acc)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        sub_d   = sub_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    idx_d   = '0;
                    state_d = (eff_cnt == '0) ? S_DONE : S_LOAD;
                end
            end
            S_LOAD: begin
                sub_d   = '0;
                state_d = S_ISSUE;
            end
            S_ISSUE: begin
                if (cmd_ready) state_d = S_WAIT_RSP;
            end
            S_WAIT_RSP: begin
                if (rsp_valid) begin
                    if (sub_last) begin
                        state_d = S_STORE;
                    end else begin
                        sub_d   = sub_q + 2'd1;
                        state_d = S_ISSUE;
                    end
                end
            end
            S_STORE: begin
                if (final_entry) begin
                    state_d = S_DONE;
                end else begin
                    idx_d   = idx_q + IDX_W'(1);
                    state_d = S_LOAD;
                end
            end
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            sub_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            sub_q   <= sub_d;
            if (state_q == S_DONE) begin
                irq_q <= 1'b1;
            end else if (clr_irq) begin
                irq_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_valid = (state_q == S_ISSUE);
        cmd_cs    = ent_cs;
        cmd_len   = sub_len;
        cmd_last  = sub_last;
        wr_en     = (state_q == S_STORE);
        wr_addr   = idx_q;
        wr_data   = ent_narrow ? (acc >> NARROW_SHIFT) : acc;
        busy      = (state_q != S_IDLE);
        irq       = irq_q;
    end

    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_len) && $stable(cmd_cs) && $stable(cmd_last)));

    // R2
    irq_with_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));

    // R1
    wr_slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (busy && (CNT_W'(wr_addr) < eff_cnt)));

    // R5
    sub_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((cmd_len >= LEN_W'(4)) && (cmd_len <= LEN_W'(SUB_W))));

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (state_q != S_DONE)) |=> busy);

    // R9
    empty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (eff_cnt == '0)) |=> (busy && !cmd_valid && !wr_en));
endmodule

// File: tb/tb_spi_sensor_seq.sv
module tb_spi_sensor_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        clr_irq = 1'b0;
    logic [2:0]  tbl_count = '0;
    logic [7:0]  tbl_cs = '0;
    logic [7:0]  tbl_split = '0;
    logic [3:0]  tbl_narrow = '0;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [1:0]  cmd_cs;
    logic [4:0]  cmd_len;
    logic        cmd_last;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [23:0] wr_data;
    logic        busy;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sensor_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .clr_irq    (clr_irq),
        .tbl_count  (tbl_count),
        .tbl_cs     (tbl_cs),
        .tbl_split  (tbl_split),
        .tbl_narrow (tbl_narrow),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_cs     (cmd_cs),
        .cmd_len    (cmd_len),
        .cmd_last   (cmd_last),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .busy       (busy),
        .irq        (irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    int run_no = 0;
    int cs_of [4];
    int sp_of [4];
    int nw_of [4];
    int sval  [4];
    int got   [4];
    int wr_cnt = 0;
    int irq_rise = 0;
    int r_ent = 0;
    int r_sub = 0;
    int r_ptr = 0;
    logic irq_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R5: bit counts per split code
    function automatic int exp_len(input int code, input int s);
        case (code)
            0: return (s == 0) ? 16 : 8;
            1: return 12;
            2: return 8;
            default: return (s == 0) ? 8 : 16;
        endcase
    endfunction

    function automatic int nsub(input int code);
        return (code == 2) ? 3 : 2;
    endfunction

    // result-port monitor
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            got[wr_addr] = int'(wr_data);
            wr_cnt++;
        end
        if (rst_n && irq && !irq_prev) irq_rise++;
        irq_prev = irq;
    end

    // SPI master and sensor model
    initial begin
        cmd_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid) begin
                int lat, rl, ln, cs, lastf, data;
                lat = (run_no + r_sub) % 3;
                rl  = (run_no * 2 + r_sub) % 4;
                repeat (lat) @(negedge clk);
                ln    = int'(cmd_len);
                cs    = int'(cmd_cs);
                lastf = int'(cmd_last);
                cmd_ready = 1'b1;
                if (r_ent < 4) begin
                    chk(ln == exp_len(sp_of[r_ent], r_sub), "R5", "sub-frame length",
                        ln, exp_len(sp_of[r_ent], r_sub));
                    chk(cs == cs_of[r_ent], "R6", "chip select", cs, cs_of[r_ent]);
                    chk(lastf == int'(r_sub == nsub(sp_of[r_ent]) - 1), "R6", "last flag",
                        lastf, int'(r_sub == nsub(sp_of[r_ent]) - 1));
                end else begin
                    chk(1'b0, "R1", "command beyond table", r_ent, 4);
                end
                @(negedge clk);
                cmd_ready = 1'b0;
                repeat (rl) @(negedge clk);
                if (ln > 0 && r_ptr + ln <= 24)
                    data = (sval[cs] >> (24 - r_ptr - ln)) & ((1 << ln) - 1);
                else
                    data = 0;
                rsp_data  = 16'(data);
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
                r_ptr += ln;
                r_sub++;
                if (lastf != 0) begin
                    chk(r_ptr == 24, "R6", "bits before select release", r_ptr, 24);
                    r_ptr = 0;
                    r_sub = 0;
                    r_ent++;
                end
            end
        end
    end

    task automatic run_seq(input int cnt, input int k, input int nar, input bit restart);
        int eff, guard, expv;
        eff = (cnt > 4) ? 4 : cnt;
        run_no++;
        for (int i = 0; i < 4; i++) begin
            cs_of[i] = (i + k) % 4;
            sp_of[i] = (i * 3 + k + cnt) % 4;
            nw_of[i] = (nar >> i) & 1;
            got[i]   = -1;
            tbl_cs[i*2 +: 2]    = 2'(cs_of[i]);
            tbl_split[i*2 +: 2] = 2'(sp_of[i]);
            tbl_narrow[i]       = nw_of[i][0];
        end
        for (int c = 0; c < 4; c++)
            sval[c] = (32'h009E3779 * (run_no + 1) + c * 32'h0013579B) & 32'h00FFFFFF;
        tbl_count = 3'(cnt);
        wr_cnt = 0;
        irq_rise = 0;
        r_ent = 0;
        r_sub = 0;
        r_ptr = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R3", "busy after trigger", busy, 1);
        if (restart) begin
            repeat (6) @(negedge clk);
            chk(busy == 1'b1, "R4", "busy before extra trigger", busy, 1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(irq == 1'b1, "R2", "irq as busy falls", irq, 1);
        repeat (3) @(negedge clk);
        chk(irq == 1'b1, "R2", "irq held", irq, 1);
        chk(busy == 1'b0, "R4", "no second run", busy, 0);
        chk(irq_rise == 1, "R2", "interrupt count", irq_rise, 1);
        chk(wr_cnt == eff, "R1", "write count", wr_cnt, eff);
        if (eff == 0) begin
            chk(r_ent == 0 && r_sub == 0, "R9", "commands on empty run", r_sub, 0);
        end
        for (int i = 0; i < eff; i++) begin
            expv = (nw_of[i] != 0) ? (sval[cs_of[i]] >> 4) : sval[cs_of[i]];
            if (nw_of[i] != 0)
                chk(got[i] == expv, "R8", "narrow result", got[i], expv);
            else
                chk(got[i] == expv, "R7", "full result", got[i], expv);
        end
        clr_irq = 1'b1;
        @(negedge clk);
        clr_irq = 1'b0;
        chk(irq == 1'b0, "R2", "irq after clear", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11
        chk(busy == 1'b0, "R11", "busy in reset", busy, 0);
        chk(irq == 1'b0, "R11", "irq in reset", irq, 0);
        chk(cmd_valid == 1'b0, "R11", "cmd_valid in reset", cmd_valid, 0);
        chk(wr_en == 1'b0, "R11", "wr_en in reset", wr_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && irq == 1'b0, "R11", "idle after reset", busy, 0);
        for (int cnt = 0; cnt <= 5; cnt++) begin
            for (int k = 0; k < 4; k++) begin
                run_seq(cnt, k, (k * 5 + cnt) & 15, (k == 2 && cnt >= 2));
            end
        end
        run_seq(4, 1, 15, 1'b1);
        run_seq(4, 3, 0, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule